// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Loader

This block is the digital front end of a two-channel 16-bit converter. A host drives a three-wire serial link made of an active-low select, a data line and a serial clock. While the select line is low, each rising serial clock edge shifts one bit into an 18-bit window. When the select line returns high, the two most significant bits of the window form an address and the low 16 bits form a data word. The data word is written into the input register of no channel, channel A, channel B or both channels, as the address selects.

Each channel also has an output register behind its input register. An active-low load pin makes the output register follow the input register while the pin is low and hold its value while the pin is high. An active-low clear pin forces both register ranks of both channels to a preset value, and a preset-select pin picks zero or midscale as that value. All serial and control pins are brought into the system clock domain through synchronizers, and their edges are detected there.

Top module: `dual_dac_loader`

## Requirements
- R1: After the system reset `rst_ni` is released, both output words read 0x0000 and neither write strobe has pulsed.
- R2: A frame is 18 bits sent MSB first. Bit 17 is address bit 1, bit 16 is address bit 0 and bits 15..0 are the data word. A bit is captured on each rising serial clock edge while `cs_ni` is low, and the data word is written when `cs_ni` rises.
- R3: The address selects the channels written: 2'b00 writes neither channel, 2'b01 writes channel A, 2'b10 writes channel B and 2'b11 writes both.
- R4: Only the 18 most recent bits count. Extra leading bits in a frame are discarded. The window is not cleared between frames, so a frame shorter than 18 bits is completed by the last bits of the earlier frames.
- R5: While `cs_ni` is high, neither serial clock edges nor transitions of `ldn_i` change the bit window.
- R6: A write strobe pulses high for exactly one system clock cycle each time its channel's input register is written from a frame.
- R7: While `ldn_i` is low, each output word follows its channel's input register. While `ldn_i` is high, each output word holds its value. Once `ldn_i` returns low, the output word takes the current input value.
- R8: While `clr_ni` is low, both ranks of both channels are forced to 0x0000 if `mid_i` is low and to 0x8000 if `mid_i` is high.
- R9: A clear has priority over a frame that completes while the clear is active. Such a frame writes no register and pulses no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| sclk_i | input | 1 | Serial clock; data captured on the rising edge |
| cs_ni | input | 1 | Active-low frame select; its rising edge commits the frame |
| sdi_i | input | 1 | Serial data, MSB first |
| ldn_i | input | 1 | Low: output registers follow input registers; high: hold |
| clr_ni | input | 1 | Active-low clear of both register ranks |
| mid_i | input | 1 | Clear preset select: 0 gives 0x0000, 1 gives 0x8000 |
| out_a_o | output | 16 | Channel A output register |
| out_b_o | output | 16 | Channel B output register |
| wr_a_o | output | 1 | One-cycle pulse when channel A's input register is written |
| wr_b_o | output | 1 | One-cycle pulse when channel B's input register is written |

## Verification
The assertions assume that the serial clock stays high and stays low for several system cycles at a time. They assume that the data line is stable across each sampled serial clock edge and that the select line never changes within a few cycles of a serial clock edge. They also assume that the clear level is held long enough to pass through the synchronizer. The bench keeps within these limits: it holds each serial clock phase for four system cycles, it sets the data and select lines four cycles before the next edge, and it holds the clear and load pins for at least six cycles. Random frames vary the address, the data, the number of leading pad bits and the load level. Directed cases cover short frames that reuse bits left in the window, clock and load toggles with the select line high, both presets, and a frame that completes during a clear.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

  typedef enum logic [1:0] {
    ADDR_NONE = 2'b00,
    ADDR_CH_A = 2'b01,
    ADDR_CH_B = 2'b10,
    ADDR_BOTH = 2'b11
  } dac_addr_e;

  localparam int ADDR_W = 2;
  localparam int NUM_CH = 2;

  // bit positions in the synchronized pin bus
  localparam int SYN_SCLK = 0;
  localparam int SYN_CS   = 1;
  localparam int SYN_SDI  = 2;
  localparam int SYN_LDN  = 3;
  localparam int SYN_CLR  = 4;
  localparam int SYN_MID  = 5;
  localparam int SYN_W    = 6;

  // select and clear idle high, everything else low
  localparam logic [SYN_W-1:0] SYN_RST = 6'b010010;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int           W      = 6,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= RST;
      prev_q <= RST;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~prev_q;

  // a detected edge lasts one cycle
  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rise_o |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/shift_win.sv
module shift_win #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);

  logic [W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   win_q <= '0;
    else if (en_i) win_q <= {win_q[W-2:0], bit_i};
  end

  assign win_o = win_q;

  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(win_q));

  p_lsb_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (win_q[0] == $past(bit_i)) && (win_q[W-1:1] == $past(win_q[W-2:0])));

endmodule

// File: rtl/chan_regs.sv
module chan_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] preset_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hold_i,
  output logic [DATA_W-1:0] out_o,
  output logic              wr_o
);

  logic [DATA_W-1:0] in_q, out_q;
  logic              wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= wr_en_i & ~clr_i;
      if (clr_i) begin
        in_q  <= preset_i;
        out_q <= preset_i;
      end else begin
        if (wr_en_i) in_q <= data_i;
        if (!hold_i) out_q <= in_q;
      end
    end
  end

  assign out_o = out_q;
  assign wr_o  = wr_q;

  p_clear_in_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (in_q == $past(preset_i)) && (out_q == $past(preset_i)));

  p_clear_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !wr_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i) |=> $stable(out_q));

  p_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !clr_i) |=> (out_q == $past(in_q)));

  p_strobe_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (in_q == $past(data_i)));

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dac_if_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              ldn_i,
  input  logic              clr_ni,
  input  logic              mid_i,
  output logic [DATA_W-1:0] out_a_o,
  output logic [DATA_W-1:0] out_b_o,
  output logic              wr_a_o,
  output logic              wr_b_o
);

  localparam int WORD_W = ADDR_W + DATA_W;

  logic [SYN_W-1:0]  pin_bus, pin_lvl, pin_rise;
  logic              shift_en, load_en, clr_s;
  logic [WORD_W-1:0] win;
  dac_addr_e         addr;
  logic [NUM_CH-1:0] sel;
  logic [DATA_W-1:0] preset;
  logic [DATA_W-1:0] ch_out [NUM_CH];
  logic [NUM_CH-1:0] ch_wr;

  always_comb begin
    pin_bus           = '0;
    pin_bus[SYN_SCLK] = sclk_i;
    pin_bus[SYN_CS]   = cs_ni;
    pin_bus[SYN_SDI]  = sdi_i;
    pin_bus[SYN_LDN]  = ldn_i;
    pin_bus[SYN_CLR]  = clr_ni;
    pin_bus[SYN_MID]  = mid_i;
  end

  pin_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST(SYN_RST)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (pin_bus),
    .level_o (pin_lvl),
    .rise_o  (pin_rise)
  );

  assign shift_en = pin_rise[SYN_SCLK] & ~pin_lvl[SYN_CS];
  assign load_en  = pin_rise[SYN_CS];
  assign clr_s    = ~pin_lvl[SYN_CLR];
  assign preset   = pin_lvl[SYN_MID] ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  shift_win #(.W(WORD_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (shift_en),
    .bit_i  (pin_lvl[SYN_SDI]),
    .win_o  (win)
  );

  assign addr = dac_addr_e'(win[WORD_W-1 -: ADDR_W]);

  always_comb begin
    unique case (addr)
      ADDR_CH_A: sel = 2'b01;
      ADDR_CH_B: sel = 2'b10;
      ADDR_BOTH: sel = 2'b11;
      default:   sel = 2'b00;
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_s),
      .preset_i (preset),
      .wr_en_i  (load_en & sel[c]),
      .data_i   (win[DATA_W-1:0]),
      .hold_i   (pin_lvl[SYN_LDN]),
      .out_o    (ch_out[c]),
      .wr_o     (ch_wr[c])
    );
  end

  assign out_a_o = ch_out[0];
  assign out_b_o = ch_out[1];
  assign wr_a_o  = ch_wr[0];
  assign wr_b_o  = ch_wr[1];

  p_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en && addr == ADDR_NONE) |=> !wr_a_o && !wr_b_o);

  p_both_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en && addr == ADDR_BOTH && !clr_s) |=> wr_a_o && wr_b_o);

  p_strobe_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a_o |=> !wr_a_o);

  p_strobe_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_b_o |=> !wr_b_o);

endmodule

// File: tb/tb_dual_dac_loader.sv
`timescale 1ns/1ps
module tb_dual_dac_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, ld_n = 1'b0, clr_n = 1'b1, mid = 1'b0;
  logic [15:0] out_a, out_b;
  logic        wr_a, wr_b;

  always #10 clk = ~clk;

  dual_dac_loader dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .ldn_i(ld_n), .clr_ni(clr_n), .mid_i(mid),
    .out_a_o(out_a), .out_b_o(out_b), .wr_a_o(wr_a), .wr_b_o(wr_b)
  );

  int checks = 0, errors = 0;
  int cnt_a = 0, cnt_b = 0, exp_a = 0, exp_b = 0;
  logic [17:0] m_win = '0;
  logic [15:0] m_in_a = '0, m_in_b = '0, m_out_a = '0, m_out_b = '0;
  bit m_ld = 0, m_clr = 0;

  always @(posedge clk) begin
    if (wr_a) cnt_a++;
    if (wr_b) cnt_b++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "out_a", {16'h0, out_a}, {16'h0, m_out_a});
    chk(req, "out_b", {16'h0, out_b}, {16'h0, m_out_b});
    chk(req, "strobes_a", cnt_a, exp_a);
    chk(req, "strobes_b", cnt_b, exp_b);
  endtask

  function automatic logic [15:0] preset_of(bit m);
    return m ? 16'h8000 : 16'h0000;
  endfunction

  task automatic follow();
    if (!m_clr && !m_ld) begin
      m_out_a = m_in_a;
      m_out_b = m_in_b;
    end
  endtask

  // serial frame of n bits, MSB first, then select release
  task automatic frame(logic [31:0] v, int n);
    cs_n = 1'b0;
    tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      tick(4);
      sclk = 1'b1;
      m_win = {m_win[16:0], v[i]};
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    if (!m_clr) begin
      if (m_win[16]) begin m_in_a = m_win[15:0]; exp_a++; end
      if (m_win[17]) begin m_in_b = m_win[15:0]; exp_b++; end
    end
    follow();
    tick(12);
  endtask

  task automatic set_ld(bit v);
    ld_n = v;
    m_ld = v;
    tick(6);
    follow();
  endtask

  task automatic clear_pulse(bit m);
    mid = m;
    tick(4);
    clr_n = 1'b0;
    m_clr = 1;
    tick(8);
    m_in_a = preset_of(m); m_in_b = preset_of(m);
    m_out_a = preset_of(m); m_out_b = preset_of(m);
  endtask

  task automatic clear_release();
    clr_n = 1'b1;
    m_clr = 0;
    tick(6);
    follow();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    tick(3);
    rst_n = 1'b1;
    tick(6);
    check_all("R1");

    // R2/R3 directed decode
    frame({14'h0, 2'b01, 16'hA5C3}, 18); check_all("R2 addr A");
    frame({14'h0, 2'b10, 16'h3C5A}, 18); check_all("R3 addr B");
    frame({14'h0, 2'b00, 16'hFFFF}, 18); check_all("R3 addr none");
    frame({14'h0, 2'b11, 16'h1357}, 18); check_all("R3 addr both");

    // R4 leading padding: three right-justified bytes
    frame({8'h0, 6'b101010, 2'b01, 16'hBEEF}, 24); check_all("R4 padded");

    // R5 clock and load toggles with select high, then a short frame
    frame({14'h0, 2'b01, 16'h00C5}, 18);
    for (int i = 0; i < 8; i++) begin
      sdi = i[0];
      tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
      ld_n = ~ld_n;
    end
    ld_n = 1'b0;
    tick(6);
    frame({22'h0, 10'h3A5}, 10); check_all("R5 R4 short frame");

    // R7 hold and release
    set_ld(1);
    frame({14'h0, 2'b11, 16'h4242}, 18); check_all("R7 hold");
    set_ld(0); check_all("R7 follow");

    // R8 presets
    clear_pulse(1); check_all("R8 midscale");
    clear_release(); check_all("R8 midscale after");
    clear_pulse(0); check_all("R8 zero");
    clear_release();
    frame({14'h0, 2'b11, 16'h7777}, 18);
    clear_pulse(1); check_all("R8 midscale again");
    // R9 frame during clear
    frame({14'h0, 2'b11, 16'h0F0F}, 18); check_all("R9 clear wins");
    clear_release(); check_all("R9 after release");

    // random frames
    for (int t = 0; t < 30; t++) begin
      int pad;
      logic [31:0] v;
      bit hold;
      pad = int'($urandom % 7);
      v = $urandom;
      v[31:18] = v[31:18] & ((14'h1 << pad) - 14'h1);
      hold = ($urandom % 4) == 0;
      if (hold) set_ld(1);
      frame(v, 18 + pad);
      check_all(hold ? "R7 random hold" : "R2 R3 R4 R6 random");
      if (hold) begin set_ld(0); check_all("R7 random release"); end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule